// File: doc/BRIEF.md
# Delayed-Branch Next-PC Resolver

This block inspects the 16-bit instruction at the current program counter and works out where execution has to resume once that instruction (and, for a delayed branch, its delay-slot companion) is retired. A fault recovery path uses it after a floating-point exception: it needs to know which of the two words at PC and PC+2 actually raised the fault, whether the link register has to be refreshed before resuming, and the resume address itself.

Every delayed branch class is understood: the 12-bit PC-relative forms, the two conditional delayed forms steered by the T flag, register-indirect jumps, PC-relative register branches and the subroutine return. For any of them the word under examination is the delay-slot word supplied on a separate input; for all other words it is the instruction itself and execution resumes at PC+2. The examined word is also matched against the single-to-double conversion encoding, and a recovery request is raised when that match coincides with the recovery-enable input. Results are captured into an output register on a valid strobe; the register-file read address is driven combinationally so the operand arrives in the same cycle.

Top module: `dslot_resolver`

## Requirements
- R1: After synchronous reset every output register is zero, including `res_valid_o`, `link_we_o` and both conversion flags.
- R2: Outputs are captured on the rising clock edge when `req_valid_i` is 1, and `res_valid_o` follows `req_valid_i` one cycle later; with `req_valid_i` at 0 every result output keeps its previous value.
- R3: When bits [15:12] are 0xA or 0xB the resume address is PC + 4 + 2 × sign-extended bits [11:0].
- R4: When bits [15:8] are 0x8D the resume address is PC + 4 + 2 × sign-extended bits [7:0] if T is 1, and PC + 4 if T is 0.
- R5: When bits [15:8] are 0x8F the resume address is PC + 4 if T is 1, and PC + 4 + 2 × sign-extended bits [7:0] if T is 0.
- R6: A word with bits [15:12] = 0x4, bits [3:0] = 0xB and bits [7:4] equal to 0x0 or 0x2 resumes at the register value; `gpr_sel_o` always presents bits [11:8] of the current instruction.
- R7: A word with bits [15:12] = 0x0, bits [3:0] = 0x3 and bits [7:4] equal to 0x0 or 0x2 resumes at PC + 4 + register value.
- R8: The word 0x000B resumes at the return-register input.
- R9: `link_we_o` is 1 only for bits [15:12] = 0xB or for bits [15:12] = 0x4 with bits [7:0] = 0x0B, and then `link_data_o` is PC + 4.
- R10: For every branch in R3 to R8 the examined word is the delay-slot input and `exam_slot_o` is 1; for every other word the examined word is the instruction, `exam_slot_o` is 0 and the resume address is PC + 2.
- R11: `cvt_match_o` is 1 when the examined word ANDed with 0xF1FF equals 0xF0AD; `cvt_pair_o` then carries its bits [11:8], and `cvt_recover_o` is 1 only when the match and `cvt_en_i` are both 1.
- R12: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Capture strobe for the current request |
| insn_i | input | 16 | Instruction word at PC |
| slot_i | input | 16 | Instruction word at PC+2 |
| pc_i | input | 32 | Address of `insn_i` |
| tflag_i | input | 1 | T condition flag |
| ret_i | input | 32 | Current return-register value |
| gpr_sel_o | output | 4 | Register-file read address |
| gpr_data_i | input | 32 | Register-file read data for `gpr_sel_o` |
| cvt_en_i | input | 1 | Recovery enable for the conversion fault |
| res_valid_o | output | 1 | Registered result valid |
| next_pc_o | output | 32 | Resume address |
| exam_word_o | output | 16 | Word identified as the faulting one |
| exam_slot_o | output | 1 | Examined word is the delay slot |
| link_we_o | output | 1 | Return register must be written |
| link_data_o | output | 32 | Value for the return register |
| cvt_match_o | output | 1 | Examined word is the single-to-double conversion |
| cvt_pair_o | output | 4 | Destination pair index of the conversion |
| cvt_recover_o | output | 1 | Conversion match with recovery enabled |

## Verification
The bench drives both senses of each conditional branch with T at 0 and 1 and with forward and backward displacements, so a design that swapped the polarity of the false-branch or dropped the sign extension would resume far from the right place. Near-miss encodings (register forms with bits [7:4] = 1, the 0x2B variant, 0x8E) must be treated as ordinary words; a loose decoder would wrongly pick the slot. The link-write set is probed with the 0x2B indirect form and the register-relative forms, which a design that linked on every call-looking word would get wrong, and a PC near the top of the address space checks the wrap. Conversion words are placed both in the slot and as the instruction, with the enable set and cleared, to catch a detector that looked at the wrong word.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int IW = 16;
    localparam int NIB = 4;

    typedef enum logic [2:0] {
        BC_PLAIN,
        BC_DISP12,
        BC_IFTRUE,
        BC_IFFALSE,
        BC_REGJMP,
        BC_REGREL,
        BC_RETURN
    } bclass_e;

    typedef struct packed {
        bclass_e cls;
        logic    link;
    } dec_t;

    // Word classification, first match wins.
    function automatic dec_t classify(input logic [IW-1:0] w);
        dec_t d;
        logic [NIB-1:0] hi, mid, lo;
        hi  = w[15:12];
        mid = w[7:4];
        lo  = w[3:0];
        d.cls  = BC_PLAIN;
        d.link = 1'b0;
        if (hi == 4'hA || hi == 4'hB) begin
            d.cls  = BC_DISP12;
            d.link = (hi == 4'hB);
        end else if (w[15:8] == 8'h8D) begin
            d.cls = BC_IFTRUE;
        end else if (w[15:8] == 8'h8F) begin
            d.cls = BC_IFFALSE;
        end else if (hi == 4'h4 && lo == 4'hB && (mid == 4'h0 || mid == 4'h2)) begin
            d.cls  = BC_REGJMP;
            d.link = (mid == 4'h0);
        end else if (hi == 4'h0 && lo == 4'h3 && (mid == 4'h0 || mid == 4'h2)) begin
            d.cls = BC_REGREL;
        end else if (w == 16'h000B) begin
            d.cls = BC_RETURN;
        end
        return d;
    endfunction

endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
    import dsr_pkg::*;
(
    input  logic [IW-1:0]  insn,
    output dec_t           dec,
    output logic [NIB-1:0] reg_sel
);
    always_comb begin
        dec     = classify(insn);
        reg_sel = insn[11:8];
    end
endmodule

// File: rtl/dsr_target.sv
module dsr_target
    import dsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [IW-1:0]   insn,
    input  dec_t            dec,
    input  logic [XLEN-1:0] pc,
    input  logic            tflag,
    input  logic [XLEN-1:0] ret,
    input  logic [XLEN-1:0] gpr,
    output logic [XLEN-1:0] next_pc,
    output logic            in_slot,
    output logic [XLEN-1:0] link_val
);
    localparam int EXT12 = XLEN - 13;
    localparam int EXT8  = XLEN - 9;

    logic [XLEN-1:0] pc_p2, pc_p4, off12, off8, base_add;
    logic            take8;

    always_comb begin
        pc_p2 = pc + XLEN'(2);
        pc_p4 = pc + XLEN'(4);
        off12 = {{EXT12{insn[11]}}, insn[11:0], 1'b0};
        off8  = {{EXT8{insn[7]}}, insn[7:0], 1'b0};
        take8 = (dec.cls == BC_IFTRUE) ? tflag : ~tflag;
        // one shared adder on PC+4 for all relative classes
        case (dec.cls)
            BC_DISP12: base_add = off12;
            BC_IFTRUE,
            BC_IFFALSE: base_add = take8 ? off8 : '0;
            BC_REGREL:  base_add = gpr;
            default:    base_add = '0;
        endcase
        case (dec.cls)
            BC_PLAIN:  next_pc = pc_p2;
            BC_REGJMP: next_pc = gpr;
            BC_RETURN: next_pc = ret;
            default:   next_pc = pc_p4 + base_add;
        endcase
        in_slot  = (dec.cls != BC_PLAIN);
        link_val = pc_p4;
    end
endmodule

// File: rtl/dsr_cvt_detect.sv
module dsr_cvt_detect
    import dsr_pkg::*;
(
    input  logic [IW-1:0]  word,
    input  logic           enable,
    output logic           match,
    output logic [NIB-1:0] pair,
    output logic           recover
);
    localparam logic [IW-1:0] CVT_MASK = 16'hF1FF;
    localparam logic [IW-1:0] CVT_CODE = 16'hF0AD;

    always_comb begin
        match   = ((word & CVT_MASK) == CVT_CODE);
        pair    = word[11:8];
        recover = match & enable;
    end
endmodule

// File: rtl/dslot_resolver.sv
module dslot_resolver
    import dsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid_i,
    input  logic [15:0]          insn_i,
    input  logic [15:0]          slot_i,
    input  logic [XLEN-1:0]      pc_i,
    input  logic                 tflag_i,
    input  logic [XLEN-1:0]      ret_i,
    output logic [3:0]           gpr_sel_o,
    input  logic [XLEN-1:0]      gpr_data_i,
    input  logic                 cvt_en_i,
    output logic                 res_valid_o,
    output logic [XLEN-1:0]      next_pc_o,
    output logic [15:0]          exam_word_o,
    output logic                 exam_slot_o,
    output logic                 link_we_o,
    output logic [XLEN-1:0]      link_data_o,
    output logic                 cvt_match_o,
    output logic [3:0]           cvt_pair_o,
    output logic                 cvt_recover_o
);
    dec_t            dec;
    logic [XLEN-1:0] nxt, lnk;
    logic            slot_sel;
    logic [IW-1:0]   exam;
    logic            c_match, c_rec;
    logic [NIB-1:0]  c_pair;

    dsr_decode u_dec (
        .insn    (insn_i),
        .dec     (dec),
        .reg_sel (gpr_sel_o)
    );

    dsr_target #(.XLEN(XLEN)) u_tgt (
        .insn     (insn_i),
        .dec      (dec),
        .pc       (pc_i),
        .tflag    (tflag_i),
        .ret      (ret_i),
        .gpr      (gpr_data_i),
        .next_pc  (nxt),
        .in_slot  (slot_sel),
        .link_val (lnk)
    );

    assign exam = slot_sel ? slot_i : insn_i;

    dsr_cvt_detect u_cvt (
        .word    (exam),
        .enable  (cvt_en_i),
        .match   (c_match),
        .pair    (c_pair),
        .recover (c_rec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o   <= 1'b0;
            next_pc_o     <= '0;
            exam_word_o   <= '0;
            exam_slot_o   <= 1'b0;
            link_we_o     <= 1'b0;
            link_data_o   <= '0;
            cvt_match_o   <= 1'b0;
            cvt_pair_o    <= '0;
            cvt_recover_o <= 1'b0;
        end else begin
            res_valid_o <= req_valid_i;
            if (req_valid_i) begin
                next_pc_o     <= nxt;
                exam_word_o   <= exam;
                exam_slot_o   <= slot_sel;
                link_we_o     <= dec.link;
                link_data_o   <= lnk;
                cvt_match_o   <= c_match;
                cvt_pair_o    <= c_pair;
                cvt_recover_o <= c_rec;
            end
        end
    end
endmodule

// File: rtl/dslot_resolver_chk.sv
module dslot_resolver_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid_i,
    input logic [15:0]     insn_i,
    input logic [15:0]     slot_i,
    input logic [XLEN-1:0] pc_i,
    input logic            cvt_en_i,
    input logic            res_valid_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic [15:0]     exam_word_o,
    input logic            exam_slot_o,
    input logic            link_we_o,
    input logic [XLEN-1:0] link_data_o,
    input logic            cvt_match_o,
    input logic            cvt_recover_o
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> res_valid_o);

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!res_valid_o && $stable(next_pc_o) && $stable(exam_word_o)));

    assert_plain_next_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && !exam_slot_o) |->
            (next_pc_o == $past(pc_i) + XLEN'(2) && exam_word_o == $past(insn_i)));

    assert_slot_word_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && exam_slot_o) |-> exam_word_o == $past(slot_i));

    assert_link_value_R9: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && link_we_o) |->
            (exam_slot_o && link_data_o == $past(pc_i) + XLEN'(4)));

    assert_recover_needs_match_R11: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && cvt_recover_o) |-> (cvt_match_o && $past(cvt_en_i)));
endmodule

bind dslot_resolver dslot_resolver_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid_i   (req_valid_i),
    .insn_i        (insn_i),
    .slot_i        (slot_i),
    .pc_i          (pc_i),
    .cvt_en_i      (cvt_en_i),
    .res_valid_o   (res_valid_o),
    .next_pc_o     (next_pc_o),
    .exam_word_o   (exam_word_o),
    .exam_slot_o   (exam_slot_o),
    .link_we_o     (link_we_o),
    .link_data_o   (link_data_o),
    .cvt_match_o   (cvt_match_o),
    .cvt_recover_o (cvt_recover_o)
);

// File: tb/sim_dslot_resolver.sv
module sim_dslot_resolver;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid_i;
    logic [15:0] insn_i, slot_i;
    logic [31:0] pc_i, ret_i, gpr_data_i;
    logic        tflag_i, cvt_en_i;
    logic [3:0]  gpr_sel_o;
    logic        res_valid_o, exam_slot_o, link_we_o, cvt_match_o, cvt_recover_o;
    logic [31:0] next_pc_o, link_data_o;
    logic [15:0] exam_word_o;
    logic [3:0]  cvt_pair_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dslot_resolver #(.XLEN(32)) u0 (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .insn_i(insn_i),
        .slot_i(slot_i), .pc_i(pc_i), .tflag_i(tflag_i), .ret_i(ret_i),
        .gpr_sel_o(gpr_sel_o), .gpr_data_i(gpr_data_i), .cvt_en_i(cvt_en_i),
        .res_valid_o(res_valid_o), .next_pc_o(next_pc_o), .exam_word_o(exam_word_o),
        .exam_slot_o(exam_slot_o), .link_we_o(link_we_o), .link_data_o(link_data_o),
        .cvt_match_o(cvt_match_o), .cvt_pair_o(cvt_pair_o), .cvt_recover_o(cvt_recover_o)
    );

    typedef struct packed {
        logic [15:0] insn;
        logic [15:0] slot;
        logic [31:0] pc;
        logic        t;
        logic        en;
        logic [31:0] gpr;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{16'hA005, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0100}, // R3 fwd
        '{16'hAFFE, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0100}, // R3 back
        '{16'hB7FF, 16'h0009, 32'h0000_1000, 1'b1, 1'b0, 32'h0000_0100}, // R3 R9
        '{16'hB800, 16'hF4AD, 32'h0000_8000, 1'b0, 1'b1, 32'h0000_0100}, // R3 R11
        '{16'h8D03, 16'h0009, 32'h0000_1000, 1'b1, 1'b0, 32'h0000_0100}, // R4 taken
        '{16'h8D03, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0100}, // R4 not
        '{16'h8DF0, 16'h0009, 32'h0000_1000, 1'b1, 1'b0, 32'h0000_0100}, // R4 back
        '{16'h8F04, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0100}, // R5 taken
        '{16'h8F04, 16'h0009, 32'h0000_1000, 1'b1, 1'b0, 32'h0000_0100}, // R5 not
        '{16'h8F80, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0100}, // R5 back
        '{16'h4A0B, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0040_0200}, // R6 R9 link
        '{16'h4A2B, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0040_0200}, // R6 no link
        '{16'h0503, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0100}, // R7
        '{16'h0523, 16'h0009, 32'h0000_1000, 1'b1, 1'b0, 32'hFFFF_FF00}, // R7 neg
        '{16'h000B, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0100}, // R8
        '{16'h6103, 16'h0009, 32'h0000_1000, 1'b1, 1'b0, 32'h0000_0100}, // R10 plain
        '{16'h8E05, 16'h0009, 32'h0000_1000, 1'b1, 1'b0, 32'h0000_0100}, // R10 near miss
        '{16'h4A1B, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0100}, // R10 near miss
        '{16'h0513, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0100}, // R10 near miss
        '{16'h002B, 16'h0009, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0100}, // R10 near miss
        '{16'hF2AD, 16'h0009, 32'h0000_2000, 1'b0, 1'b1, 32'h0000_0100}, // R11 insn
        '{16'hF2AD, 16'h0009, 32'h0000_2000, 1'b0, 1'b0, 32'h0000_0100}, // R11 no en
        '{16'hF0BD, 16'h0009, 32'h0000_2000, 1'b0, 1'b1, 32'h0000_0100}, // R11 miss
        '{16'hF3AD, 16'h0009, 32'h0000_2000, 1'b0, 1'b1, 32'h0000_0100}, // R11 miss
        '{16'hA7FF, 16'h0009, 32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0000_0100}, // R12 wrap
        '{16'hFFFE, 16'h0009, 32'hFFFF_FFFE, 1'b0, 1'b0, 32'h0000_0100}  // R12 wrap
    };

    localparam logic [31:0] RET_VAL = 32'h5555_0000;

    // Independent reference built from the requirement text.
    function automatic void model(input vec_t v, output logic [31:0] nxt,
                                  output logic slot, output logic lnk);
        int d12, d8;
        logic [3:0] a, b, c, e;
        a = v.insn[15:12]; b = v.insn[11:8]; c = v.insn[7:4]; e = v.insn[3:0];
        d12 = int'(v.insn[11:0]); if (d12 >= 2048) d12 = d12 - 4096;
        d8  = int'(v.insn[7:0]);  if (d8 >= 128)   d8 = d8 - 256;
        slot = 1'b1; lnk = 1'b0;
        if (a == 4'hA || a == 4'hB) begin
            nxt = v.pc + 32'd4 + 32'(d12 * 2); lnk = (a == 4'hB);
        end else if (a == 4'h8 && b == 4'hD) begin
            nxt = v.t ? v.pc + 32'd4 + 32'(d8 * 2) : v.pc + 32'd4;
        end else if (a == 4'h8 && b == 4'hF) begin
            nxt = v.t ? v.pc + 32'd4 : v.pc + 32'd4 + 32'(d8 * 2);
        end else if (a == 4'h4 && e == 4'hB && (c == 4'h0 || c == 4'h2)) begin
            nxt = v.gpr; lnk = (c == 4'h0);
        end else if (a == 4'h0 && e == 4'h3 && (c == 4'h0 || c == 4'h2)) begin
            nxt = v.pc + 32'd4 + v.gpr;
        end else if (v.insn == 16'h000B) begin
            nxt = RET_VAL;
        end else begin
            nxt = v.pc + 32'd2; slot = 1'b0;
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic valid);
        insn_i = v.insn; slot_i = v.slot; pc_i = v.pc; tflag_i = v.t;
        cvt_en_i = v.en; gpr_data_i = v.gpr; ret_i = RET_VAL; req_valid_i = valid;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] en;
        logic        es, el, m;
        logic [15:0] ew;
        rst = 1'b1;
        drive(VEC[0], 1'b1);
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 res_valid", 32'(res_valid_o), 32'd0);
        check("R1 next_pc", next_pc_o, 32'd0);
        check("R1 link_we", 32'(link_we_o), 32'd0);
        check("R1 cvt flags", 32'({cvt_match_o, cvt_recover_o}), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i], 1'b1);
            // R6: register address is combinational from bits [11:8]
            #1 check("R6 gpr_sel", 32'(gpr_sel_o), 32'(VEC[i].insn[11:8]));
            @(negedge clk);
            model(VEC[i], en, es, el);
            ew = es ? VEC[i].slot : VEC[i].insn;
            m  = (ew[15:12] == 4'hF) && (ew[8] == 1'b0) && (ew[7:0] == 8'hAD);
            check($sformatf("R3-8/R12 next_pc vec%0d", i), next_pc_o, en);
            check($sformatf("R10 exam_slot vec%0d", i), 32'(exam_slot_o), 32'(es));
            check($sformatf("R10 exam_word vec%0d", i), 32'(exam_word_o), 32'(ew));
            check($sformatf("R9 link_we vec%0d", i), 32'(link_we_o), 32'(el));
            if (el) check($sformatf("R9 link_data vec%0d", i), link_data_o, VEC[i].pc + 32'd4);
            check($sformatf("R11 match vec%0d", i), 32'(cvt_match_o), 32'(m));
            check($sformatf("R11 recover vec%0d", i), 32'(cvt_recover_o), 32'(m & VEC[i].en));
            if (m) check($sformatf("R11 pair vec%0d", i), 32'(cvt_pair_o), 32'(ew[11:8]));
            check($sformatf("R2 res_valid vec%0d", i), 32'(res_valid_o), 32'd1);
        end

        // R2: idle cycle keeps outputs although inputs change
        drive(VEC[0], 1'b1);
        @(negedge clk);
        drive(VEC[14], 1'b0);
        @(negedge clk);
        check("R2 idle res_valid", 32'(res_valid_o), 32'd0);
        check("R2 idle next_pc held", next_pc_o, 32'h0000_100E);
        check("R2 idle exam_word held", 32'(exam_word_o), 32'h0000_0009);

        // Hand-computed spot values
        drive(VEC[1], 1'b1);
        @(negedge clk);
        check("R3 back disp", next_pc_o, 32'h0000_1000);
        drive(VEC[9], 1'b1);
        @(negedge clk);
        check("R5 back disp", next_pc_o, 32'h0000_0F04);
        drive(VEC[24], 1'b1);
        @(negedge clk);
        check("R12 wrap", next_pc_o, 32'h0000_0FFE);
        drive(VEC[3], 1'b1);
        @(negedge clk);
        check("R11 slot pair", 32'({cvt_match_o, cvt_recover_o, cvt_pair_o}), 32'h34);

        // R1: reset clears a live result
        rst = 1'b1;
        @(negedge clk);
        check("R1 re-reset link_we", 32'(link_we_o), 32'd0);
        check("R1 re-reset exam_word", 32'(exam_word_o), 32'd0);
        rst = 1'b0;

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule